// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point words in the 32-bit single-precision layout. It returns a single-precision result and two flags that mark exponent overflow and exponent underflow. One operation can enter per clock cycle. A valid strobe travels through the pipeline next to the data, so the caller tags an operation at the input and collects it when the output strobe rises.

The datapath works in this order:
- It unpacks both operands and finds the one with the larger exponent.
- It shifts the other significand right, keeping guard, round and sticky bits.
- It either adds the significands without sign, or subtracts them by adding a two's complement. The carry out of that subtract decides the sign of the result.
- It normalizes the sum, rounds to nearest with ties to even, and normalizes again if the rounding carries out.

NaN and infinity operands bypass the arithmetic. The exponent and fraction widths are parameters. The PIPE parameter chooses between one and two register stages.

Top module: `fp_addsub`

## Requirements
- R1: A word holds the sign in bit 31, the biased exponent (bias 127) in bits 30:23 and the fraction in bits 22:0. For finite operands whose sum lands in the normal range, the result is the exact sum rounded to 24 significant bits with round-to-nearest, ties to even. Example: 0x3F000000 + 0xBEE00000 = 0x3D800000.
- R2: When i_sub is 1, the block computes i_a minus i_b. When i_sub is 0, it computes i_a plus i_b.
- R3: o_valid rises exactly 1+PIPE clock cycles after i_valid (2 cycles with the default PIPE=1). While o_valid is 0, o_res, o_ovf and o_unf hold their previous values. After reset, all outputs are 0.
- R4: An exactly zero result, including -0 plus -0, gives +0 (0x00000000) with both flags at 0.
- R5: Any NaN operand (exponent 255, nonzero fraction) gives the quiet NaN 0x7FC00000 with both flags at 0.
- R6: Infinities of opposite effective sign give 0x7FC00000. An infinity combined with a finite value, or with an infinity of the same sign, gives that infinity. In all these cases both flags are 0.
- R7: If the rounded exponent reaches 255 or more, the result is an infinity carrying the result sign, and o_ovf is 1.
- R8: If a nonzero result has a rounded biased exponent below 1, the result is +0 and o_unf is 1.
- R9: An operand with exponent 0 and a nonzero fraction is read as 0.f times 2^-126. Example: 0x00400000 + 0x00400000 = 0x00800000 with no flags.
- R10: If rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero. Example: 0x3FFFFFFF + 0x33800000 = 0x40000000. A tie with an even LSB rounds down: 0x3F800000 + 0x33800000 = 0x3F800000.
- R11: In an effective subtract, the result takes the sign of the operand with the larger magnitude. Example: 0x3F800000 - 0x40400000 = 0xC0000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Operation strobe |
| i_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| i_a | input | 32 | First operand |
| i_b | input | 32 | Second operand |
| o_valid | output | 1 | Result strobe |
| o_res | output | 32 | Result word |
| o_ovf | output | 1 | Exponent overflow |
| o_unf | output | 1 | Exponent underflow, result flushed to +0 |

## Verification
The bench targets the cases that expose each common fault:
- Exact cancellation: a design that keeps the sign of the negated path returns -0.
- Subtracts with equal exponents and a larger second significand: a design that ignores the missing carry returns the raw two's-complement pattern with the wrong sign.
- Ties at the half-ULP point: a design that drops sticky or the even test rounds the wrong way.
- An all-ones significand plus half an ULP: a design that does not renormalize after rounding returns a fraction of zero with an exponent one too low.

The bench also drives the largest finite values to force overflow, subtracts close denormals to force underflow, and applies NaN and opposite-infinity inputs. Seeded random operands, many with nearby exponents, cover heavy cancellation paths.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   typedef enum logic [1:0] {
      CL_ZERO = 2'd0,
      CL_FIN  = 2'd1,
      CL_INF  = 2'd2,
      CL_NAN  = 2'd3
   } cls_t;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]      i_word,
   input  logic              i_neg,
   output logic              o_sign,
   output logic [EXP_W-1:0]  o_exp,
   output logic [FRAC_W:0]   o_sig,
   output fpa_pkg::cls_t     o_cls
);
   logic [EXP_W-1:0]  fld_e;
   logic [FRAC_W-1:0] fld_f;
   logic              e_lo, e_hi, f_nz;

   always_comb begin
      fld_e  = i_word[W-2:FRAC_W];
      fld_f  = i_word[FRAC_W-1:0];
      e_lo   = (fld_e == '0);
      e_hi   = &fld_e;
      f_nz   = |fld_f;
      o_sign = i_word[W-1] ^ i_neg;
      o_exp  = e_lo ? EXP_W'(1) : fld_e;
      o_sig  = {~e_lo, fld_f};
      if (e_hi)       o_cls = f_nz ? fpa_pkg::CL_NAN : fpa_pkg::CL_INF;
      else if (e_lo)  o_cls = f_nz ? fpa_pkg::CL_FIN : fpa_pkg::CL_ZERO;
      else            o_cls = fpa_pkg::CL_FIN;
   end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SW    = FRAC_W + 1,
   localparam int GW    = SW + 3
) (
   input  logic              i_a_sign,
   input  logic [EXP_W-1:0]  i_a_exp,
   input  logic [SW-1:0]     i_a_sig,
   input  logic              i_b_sign,
   input  logic [EXP_W-1:0]  i_b_exp,
   input  logic [SW-1:0]     i_b_sig,
   output logic              o_sign,
   output logic [EXP_W-1:0]  o_exp,
   output logic [GW:0]       o_mag
);
   logic              swap, s_big, s_sml, eff_sub;
   logic [EXP_W-1:0]  e_big, e_sml, diff;
   logic [SW-1:0]     m_big, m_sml;
   int unsigned       dcl;
   logic [2*GW-1:0]   ext, shd;
   logic [GW-1:0]     big_x, al;
   logic [GW:0]       t;

   always_comb begin
      swap  = (i_b_exp > i_a_exp);
      s_big = swap ? i_b_sign : i_a_sign;
      e_big = swap ? i_b_exp  : i_a_exp;
      m_big = swap ? i_b_sig  : i_a_sig;
      s_sml = swap ? i_a_sign : i_b_sign;
      e_sml = swap ? i_a_exp  : i_b_exp;
      m_sml = swap ? i_a_sig  : i_b_sig;
      diff  = e_big - e_sml;
      dcl   = (int'(diff) > GW) ? GW : int'(diff);
      ext   = {m_sml, 3'b000, {GW{1'b0}}};
      shd   = ext >> dcl;
      al    = {shd[2*GW-1:GW+1], shd[GW] | (|shd[GW-1:0])};
      big_x = {m_big, 3'b000};
      eff_sub = s_big ^ s_sml;
      o_exp = e_big;
      t     = '0;
      if (!eff_sub) begin
         o_mag  = {1'b0, big_x} + {1'b0, al};
         o_sign = s_big;
      end else begin
         t = {1'b0, big_x} + {1'b0, ~al} + (GW+1)'(1);
         if (t[GW]) begin
            o_mag  = {1'b0, t[GW-1:0]};
            o_sign = s_big;
         end else begin
            o_mag  = {1'b0, (~t[GW-1:0]) + GW'(1)};
            o_sign = ~s_big;
         end
      end
   end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SW    = FRAC_W + 1,
   localparam int GW    = SW + 3,
   localparam int XE    = EXP_W + 2,
   localparam int EMAX  = (1 << EXP_W) - 1
) (
   input  logic              i_sign,
   input  logic [EXP_W-1:0]  i_exp,
   input  logic [GW:0]       i_mag,
   output logic [W-1:0]      o_word,
   output logic              o_ovf,
   output logic              o_unf,
   output logic              o_lead
);
   logic [$clog2(GW+1)-1:0] lz;
   logic [GW-1:0]           n;
   logic signed [XE-1:0]    ez, e1, e2;
   logic                    up;
   logic [SW:0]             r;
   logic [FRAC_W-1:0]       frac;

   always_comb begin
      lz = '0;
      for (int i = 0; i < GW; i++)
         if (i_mag[i]) lz = ($clog2(GW+1))'(GW - 1 - i);
      ez = signed'({2'b00, i_exp});
      if (i_mag[GW]) begin
         n  = {i_mag[GW:2], i_mag[1] | i_mag[0]};
         e1 = ez + XE'(1);
      end else begin
         n  = i_mag[GW-1:0] << lz;
         e1 = ez - signed'(XE'(lz));
      end
      up = n[2] & (n[1] | n[0] | n[3]);
      r  = {1'b0, n[GW-1:3]} + (SW+1)'(up);
      if (r[SW]) begin
         frac = '0;
         e2   = e1 + XE'(1);
      end else begin
         frac = r[FRAC_W-1:0];
         e2   = e1;
      end
      o_lead = n[GW-1];
      o_ovf  = 1'b0;
      o_unf  = 1'b0;
      if (i_mag == '0) begin
         o_word = '0;
      end else if (int'(e2) >= EMAX) begin
         o_word = {i_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         o_ovf  = 1'b1;
      end else if (int'(e2) < 1) begin
         o_word = '0;
         o_unf  = 1'b1;
      end else begin
         o_word = {i_sign, e2[EXP_W-1:0], frac};
      end
   end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int PIPE   = 1,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SW    = FRAC_W + 1,
   localparam int GW    = SW + 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         i_valid,
   input  logic         i_sub,
   input  logic [W-1:0] i_a,
   input  logic [W-1:0] i_b,
   output logic         o_valid,
   output logic [W-1:0] o_res,
   output logic         o_ovf,
   output logic         o_unf
);
   import fpa_pkg::*;

   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   initial begin
      assert (PIPE == 0 || PIPE == 1) else $error("PIPE must be 0 or 1");
      assert (EXP_W >= 3)             else $error("EXP_W too small");
      assert (FRAC_W >= 2)            else $error("FRAC_W too small");
   end

   logic             sa, sb;
   logic [EXP_W-1:0] ea, eb;
   logic [SW-1:0]    ma, mb;
   cls_t             ca, cb;

   fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_upa (
      .i_word(i_a), .i_neg(1'b0), .o_sign(sa), .o_exp(ea), .o_sig(ma), .o_cls(ca));
   fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_upb (
      .i_word(i_b), .i_neg(i_sub), .o_sign(sb), .o_exp(eb), .o_sig(mb), .o_cls(cb));

   // special operands bypass the arithmetic
   logic         sp;
   logic [W-1:0] spw;
   always_comb begin
      sp  = 1'b1;
      spw = QNAN;
      if (ca == CL_NAN || cb == CL_NAN)      spw = QNAN;
      else if (ca == CL_INF && cb == CL_INF) spw = (sa == sb) ? {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}} : QNAN;
      else if (ca == CL_INF)                 spw = {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (cb == CL_INF)                 spw = {sb, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else                                   sp  = 1'b0;
   end

   logic             ad_sign;
   logic [EXP_W-1:0] ad_exp;
   logic [GW:0]      ad_mag;

   fpa_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_add (
      .i_a_sign(sa), .i_a_exp(ea), .i_a_sig(ma),
      .i_b_sign(sb), .i_b_exp(eb), .i_b_sig(mb),
      .o_sign(ad_sign), .o_exp(ad_exp), .o_mag(ad_mag));

   logic             st_v, st_sp, st_sign;
   logic [W-1:0]     st_spw;
   logic [EXP_W-1:0] st_exp;
   logic [GW:0]      st_mag;

   generate
      if (PIPE == 1) begin : g_stage
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st_v <= 1'b0;
            else        st_v <= i_valid;
         always_ff @(posedge clk)
            if (i_valid) begin
               st_sp   <= sp;
               st_spw  <= spw;
               st_sign <= ad_sign;
               st_exp  <= ad_exp;
               st_mag  <= ad_mag;
            end
      end else begin : g_flow
         always_comb begin
            st_v    = i_valid;
            st_sp   = sp;
            st_spw  = spw;
            st_sign = ad_sign;
            st_exp  = ad_exp;
            st_mag  = ad_mag;
         end
      end
   endgenerate

   logic [W-1:0] nr_word;
   logic         nr_ovf, nr_unf, nr_lead;

   fpa_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nrm (
      .i_sign(st_sign), .i_exp(st_exp), .i_mag(st_mag),
      .o_word(nr_word), .o_ovf(nr_ovf), .o_unf(nr_unf), .o_lead(nr_lead));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_res   <= '0;
         o_ovf   <= 1'b0;
         o_unf   <= 1'b0;
      end else begin
         o_valid <= st_v;
         if (st_v) begin
            o_res <= st_sp ? st_spw : nr_word;
            o_ovf <= !st_sp && nr_ovf;
            o_unf <= !st_sp && nr_unf;
         end
      end
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid == $past(i_valid, PIPE + 1));
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> ($stable(o_res) && $stable(o_ovf) && $stable(o_unf)));
   // R1
   norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v && !st_sp && (st_mag != '0)) |-> nr_lead);
   // R7
   ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_ovf |-> ((&o_res[W-2:FRAC_W]) && (o_res[FRAC_W-1:0] == '0) && !o_unf));
   // R8
   unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_unf |-> (o_res == '0));
   // R5
   nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && (&o_res[W-2:FRAC_W]) && (|o_res[FRAC_W-1:0])) |-> (o_res == QNAN && !o_ovf));
endmodule

// File: tb/sim_fp_addsub.sv
`timescale 1ns/1ps
module sim_fp_addsub;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic        i_sub = 1'b0;
   logic [31:0] i_a = '0, i_b = '0;
   logic        o_valid, o_ovf, o_unf;
   logic [31:0] o_res;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fp_addsub u0 (.clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sub(i_sub),
                 .i_a(i_a), .i_b(i_b), .o_valid(o_valid), .o_res(o_res),
                 .o_ovf(o_ovf), .o_unf(o_unf));

   function automatic real pow2(int e);
      real r = 1.0;
      if (e >= 0) for (int k = 0; k < e; k++) r = r * 2.0;
      else        for (int k = 0; k < -e; k++) r = r / 2.0;
      return r;
   endfunction

   function automatic real val_of(logic s, logic [7:0] e, logic [22:0] f);
      real v;
      if (e == 0) v = real'(f) * pow2(-149);
      else        v = real'({1'b1, f}) * pow2(int'(e) - 150);
      return s ? -v : v;
   endfunction

   // returns {ovf, unf, word}
   function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, logic sub);
      logic sa = a[31];
      logic sb = b[31] ^ sub;
      bit na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      bit nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      bit ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
      bit ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
      real s;
      logic [63:0] bits;
      int es;
      logic [22:0] keep;
      logic [28:0] rest;
      logic [24:0] m;
      bit up;
      if (na || nb) return {2'b00, 32'h7FC00000};
      if (ia && ib) return (sa == sb) ? {2'b00, sa, 8'hFF, 23'h0} : {2'b00, 32'h7FC00000};
      if (ia) return {2'b00, sa, 8'hFF, 23'h0};
      if (ib) return {2'b00, sb, 8'hFF, 23'h0};
      s = val_of(sa, a[30:23], a[22:0]) + val_of(sb, b[30:23], b[22:0]);
      if (s == 0.0) return 34'h0;
      bits = $realtobits(s);
      es   = int'(bits[62:52]) - 1023 + 127;
      keep = bits[51:29];
      rest = bits[28:0];
      up   = (rest > 29'h1000_0000) || (rest == 29'h1000_0000 && keep[0]);
      m    = {2'b01, keep} + 25'(up);
      if (m[24]) begin es = es + 1; keep = '0; end
      else keep = m[22:0];
      if (es >= 255) return {2'b10, bits[63], 8'hFF, 23'h0};
      if (es < 1)    return {2'b01, 32'h0};
      return {2'b00, bits[63], 8'(es), keep};
   endfunction

   task automatic check(string tag, logic [33:0] got, logic [33:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got ovf=%0b unf=%0b res=%08h, expected ovf=%0b unf=%0b res=%08h",
                  tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
      end
   endtask

   task automatic run_op(string tag, logic [31:0] a, logic [31:0] b, logic sub,
                         logic [33:0] exp, bit chk_hold);
      logic [33:0] got;
      @(negedge clk);
      i_a = a; i_b = b; i_sub = sub; i_valid = 1'b1;
      @(negedge clk);
      i_valid = 1'b0;
      i_a = $urandom; i_b = $urandom; i_sub = $urandom;
      repeat (LAT - 1) @(negedge clk);
      check({tag, " R3 valid"}, {33'h0, o_valid}, 34'h1);
      got = {o_ovf, o_unf, o_res};
      check(tag, got, exp);
      if (chk_hold) begin
         @(negedge clk);
         check({tag, " R3 hold"}, {o_valid, o_ovf, o_unf, o_res}, {1'b0, got});
      end
   endtask

   function automatic logic [31:0] rnd_op(logic [7:0] near);
      logic [31:0] w = $urandom;
      int sel = $urandom % 16;
      int e;
      if (sel == 0)      w[30:23] = 8'hFF;
      else if (sel == 1) w[30:23] = 8'h00;
      else if (sel < 9) begin
         e = int'(near) + int'($urandom % 5) - 2;
         if (e < 0) e = 0;
         if (e > 254) e = 254;
         w[30:23] = 8'(e);
      end
      if (sel == 2) w[22:0] = '0;
      return w;
   endfunction

   initial begin
      #(100000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R3 reset", {o_valid, o_ovf, o_unf, o_res}, 35'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 after reset", {o_valid, o_ovf, o_unf, o_res}, 35'h0);

      run_op("R1 half plus neg",   32'h3F000000, 32'hBEE00000, 1'b0, {2'b00, 32'h3D800000}, 1);
      run_op("R2 sub same",        32'h3F800000, 32'h3F800000, 1'b1, 34'h0, 1);
      run_op("R2 sub neg",         32'h40000000, 32'hBF800000, 1'b1, {2'b00, 32'h40400000}, 0);
      run_op("R4 neg zeros",       32'h80000000, 32'h80000000, 1'b0, 34'h0, 0);
      run_op("R4 cancel",          32'hC1200000, 32'h41200000, 1'b0, 34'h0, 0);
      run_op("R5 nan a",           32'h7F800001, 32'h3F800000, 1'b0, {2'b00, 32'h7FC00000}, 0);
      run_op("R5 nan b",           32'h3F800000, 32'hFFFFFFFF, 1'b1, {2'b00, 32'h7FC00000}, 0);
      run_op("R6 inf minus inf",   32'h7F800000, 32'hFF800000, 1'b0, {2'b00, 32'h7FC00000}, 0);
      run_op("R6 inf sub inf",     32'h7F800000, 32'h7F800000, 1'b1, {2'b00, 32'h7FC00000}, 0);
      run_op("R6 inf plus fin",    32'h3F800000, 32'hFF800000, 1'b0, {2'b00, 32'hFF800000}, 0);
      run_op("R7 overflow pos",    32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000}, 1);
      run_op("R7 overflow neg",    32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b10, 32'hFF800000}, 0);
      run_op("R8 underflow",       32'h00800001, 32'h00800000, 1'b1, {2'b01, 32'h0}, 1);
      run_op("R8 underflow norm",  32'h00C00000, 32'h80BFFFFF, 1'b0, {2'b01, 32'h0}, 0);
      run_op("R9 denorm sum",      32'h00400000, 32'h00400000, 1'b0, {2'b00, 32'h00800000}, 0);
      run_op("R9 denorm plus norm",32'h00800000, 32'h00000001, 1'b0, {2'b00, 32'h00800001}, 0);
      run_op("R10 round carry",    32'h3FFFFFFF, 32'h33800000, 1'b0, {2'b00, 32'h40000000}, 0);
      run_op("R10 tie even",       32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000}, 0);
      run_op("R10 tie odd",        32'h3F800001, 32'h33800000, 1'b0, {2'b00, 32'h3F800002}, 0);
      run_op("R11 sub negative",   32'h3F800000, 32'h40400000, 1'b1, {2'b00, 32'hC0000000}, 0);
      run_op("R11 add mixed",      32'hBF800000, 32'h40400000, 1'b0, {2'b00, 32'h40000000}, 0);
      run_op("R11 equal exp swap", 32'h3F800000, 32'h3FC00000, 1'b1, {2'b00, 32'hBF000000}, 0);

      for (int k = 0; k < 2500; k++) begin
         logic [31:0] a = rnd_op(8'($urandom % 256));
         logic [31:0] b = rnd_op(a[30:23]);
         logic        s = $urandom;
         run_op("R1 R2 random", a, b, s, model(a, b, s), 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule